// File: doc/BRIEF.md
# Bootstrap Refresh Pulse Generator

This block keeps the high-side gate supply of a buck power stage alive. It looks at two comparator flags on the bootstrap capacitor. One flag says the capacitor voltage is under a low threshold (near 3.1 V). The other says it is over a high threshold (near 3.8 V).

When the stage is enabled, the supply is good and the low flag is seen, the block enters refresh. While in refresh, it raises a signal that tells the gate sequencer to disregard the PWM command. It also issues narrow low-side turn-on requests at a fixed repetition interval. Each request pulls the switch node to ground so that the capacitor can recharge.

Refresh ends when the high flag is seen. Between the two thresholds the block keeps its present state, so the loop is hysteretic. Losing enable or supply ends refresh at once, and any request in progress is cut off.

The pulse width `PULSE_W` and the repetition period `PERIOD` are given in clock cycles. With a 200 MHz clock, the defaults (30 and 2000) give 150 ns pulses every 10 µs. `PULSE_W` must be at least 1 and less than `PERIOD`.

Top module: `boot_refresh_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released with no other stimulus, `refresh_active` and `ls_pulse_req` are both 0.
- R2: If the block is not in refresh, and `drv_en`, `supply_ok` and `boot_low` are all 1 at a rising clock edge, then `refresh_active` is 1 after that edge.
- R3: If `drv_en` or `supply_ok` is 0, refresh never starts, whatever `boot_low` shows.
- R4: The first low-side request is driven one clock after `refresh_active` rises, provided refresh continues.
- R5: During refresh, `ls_pulse_req` is 1 for exactly `PULSE_W` cycles out of every `PERIOD` cycles. Each new pulse begins `PERIOD` cycles after the previous one began.
- R6: If `boot_ok` is 1 at an edge while refresh is active, both outputs are 0 after that edge.
- R7: While refresh is active with `boot_low` and `boot_ok` both 0, refresh and its pulse train continue unchanged.
- R8: If `drv_en` or `supply_ok` is 0 at an edge, both outputs are 0 after that edge, even in the middle of a pulse.
- R9: `ls_pulse_req` is never 1 while `refresh_active` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_en | input | 1 | Stage enable, already synchronised |
| supply_ok | input | 1 | Supply out of undervoltage |
| boot_low | input | 1 | Bootstrap voltage is below the low threshold |
| boot_ok | input | 1 | Bootstrap voltage is above the high threshold |
| refresh_active | output | 1 | Refresh in progress; the sequencer must ignore PWM |
| ls_pulse_req | output | 1 | Low-side turn-on request |

## Verification
Several input patterns are applied:
- `boot_low` with the stage disabled, which separates gating by enable from gating by the flag.
- A sustained low flag, which exposes the first-pulse latency, the pulse width and the pulse spacing over several periods.
- A release of the low flag into the band between the thresholds, which distinguishes true hysteresis from a level follower.
- Assertion of `boot_ok`, which checks the exit.
- Loss of supply and loss of enable timed in the middle of a pulse, which show whether an active request is cut short rather than finished.

// File: rtl/boot_refresh_pkg.sv
package boot_refresh_pkg;

    typedef enum logic {
        BRF_IDLE = 1'b0,
        BRF_RUN  = 1'b1
    } brf_mode_e;

    function automatic int unsigned brf_cnt_w(int unsigned period);
        return (period > 1) ? $clog2(period) : 1;
    endfunction

endpackage

// File: rtl/brf_hyst.sv
module brf_hyst
    import boot_refresh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic boot_low_i,
    input  logic boot_ok_i,
    output logic active_o,
    output logic start_o,
    output logic hold_o
);

    typedef struct packed {
        brf_mode_e mode;
    } hyst_st_t;

    hyst_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = 1'b0;
        hold_o  = 1'b0;
        if (!armed_i) begin
            st_d.mode = BRF_IDLE;
        end else begin
            case (st_q.mode)
                BRF_IDLE: begin
                    if (boot_low_i) begin
                        st_d.mode = BRF_RUN;
                        start_o   = 1'b1;
                    end
                end
                default: begin
                    if (boot_ok_i) begin
                        st_d.mode = BRF_IDLE;
                    end else begin
                        hold_o = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: BRF_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.mode == BRF_RUN);

    AST_NO_START_WITHOUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !boot_low_i) |=> !active_o); // R2
    AST_START_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && boot_low_i && armed_i) |=> active_o); // R2
    AST_END_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && boot_ok_i) |=> !active_o); // R6
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && armed_i && !boot_ok_i) |=> active_o); // R7

endmodule

// File: rtl/brf_pulse_timer.sv
module brf_pulse_timer
    import boot_refresh_pkg::*;
#(
    parameter int unsigned PULSE_W = 30,
    parameter int unsigned PERIOD  = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic hold_i,
    output logic pulse_o
);

    localparam int unsigned CW = brf_cnt_w(PERIOD);
    localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] WIDTH = CW'(PULSE_W);

    typedef struct packed {
        logic [CW-1:0] phase;
        logic          pulse;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d.phase = '0;
        st_d.pulse = 1'b0;
        if (start_i) begin
            st_d.phase = LAST;
        end else if (hold_i) begin
            st_d.phase = (st_q.phase == LAST) ? '0 : st_q.phase + CW'(1);
            st_d.pulse = (st_d.phase < WIDTH);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: '0, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && st_q.phase == WIDTH - CW'(1)) |=> !pulse_o); // R5
    AST_FIRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i ##1 hold_i |=> pulse_o); // R4
    AST_NO_PULSE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !pulse_o); // R4

endmodule

// File: rtl/boot_refresh_gen.sv
module boot_refresh_gen #(
    parameter int unsigned PULSE_W = 30,
    parameter int unsigned PERIOD  = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_en,
    input  logic supply_ok,
    input  logic boot_low,
    input  logic boot_ok,
    output logic refresh_active,
    output logic ls_pulse_req
);

    logic armed;
    logic start;
    logic hold;

    assign armed = drv_en & supply_ok;

    brf_hyst i_hyst (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed_i    (armed),
        .boot_low_i (boot_low),
        .boot_ok_i  (boot_ok),
        .active_o   (refresh_active),
        .start_o    (start),
        .hold_o     (hold)
    );

    brf_pulse_timer #(
        .PULSE_W (PULSE_W),
        .PERIOD  (PERIOD)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .hold_i  (hold),
        .pulse_o (ls_pulse_req)
    );

    AST_PULSE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ls_pulse_req |-> refresh_active); // R9
    AST_DROP_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (!refresh_active && !ls_pulse_req)); // R8
    AST_NO_START_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !refresh_active) |=> !refresh_active); // R3

endmodule

// File: tb/test_boot_refresh_gen.sv
`timescale 1ns/1ps
module test_boot_refresh_gen;

    localparam int PW = 3;
    localparam int PER = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_en = 1'b0;
    logic supply_ok = 1'b0;
    logic boot_low = 1'b0;
    logic boot_ok = 1'b0;
    logic refresh_active;
    logic ls_pulse_req;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // reference model state
    bit m_active = 0;
    int m_age = 0;

    always #2.5 clk = ~clk;

    boot_refresh_gen #(.PULSE_W(PW), .PERIOD(PER)) i_boot_refresh_gen (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .supply_ok(supply_ok),
        .boot_low(boot_low), .boot_ok(boot_ok),
        .refresh_active(refresh_active), .ls_pulse_req(ls_pulse_req)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active <= 0;
            m_age    <= 0;
        end else if (!(drv_en && supply_ok)) begin
            m_active <= 0;
        end else if (m_active) begin
            if (boot_ok) m_active <= 0;
            else m_age <= m_age + 1;
        end else if (boot_low) begin
            m_active <= 1;
            m_age    <= -1;
        end
    end

    function automatic bit exp_pulse();
        return m_active && (m_age >= 0) && ((m_age % PER) < PW);
    endfunction

    task automatic check_now();
        bit ep;
        ep = exp_pulse();
        checks++;
        if (refresh_active !== m_active) begin
            fails++;
            $display("FAIL %s refresh_active actual=%b expected=%b at %0t",
                     cur_req, refresh_active, m_active, $time);
        end
        checks++;
        if (ls_pulse_req !== ep) begin
            fails++;
            $display("FAIL %s ls_pulse_req actual=%b expected=%b at %0t",
                     cur_req, ls_pulse_req, ep, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(50000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        boot_low = 1'b1;
        step(3);
        rst_n = 1'b1;
        boot_low = 1'b0;
        step(2);

        // R3: low flag while disabled or without supply
        cur_req = "R3";
        boot_low = 1'b1;
        step(10);
        drv_en = 1'b1;
        step(10);
        drv_en = 1'b0;
        supply_ok = 1'b1;
        step(10);

        // R2, R4, R5, R9: start and a run of pulses
        cur_req = "R2/R4/R5/R9";
        drv_en = 1'b1;
        step(4 * PER + 5);

        // R7: inside the hysteresis band
        cur_req = "R7";
        boot_low = 1'b0;
        step(3 * PER);

        // R6: exit on the high flag
        cur_req = "R6";
        boot_ok = 1'b1;
        step(6);
        boot_ok = 1'b0;
        step(4);

        // R8: loss of supply mid-pulse
        cur_req = "R8";
        boot_low = 1'b1;
        step(3);
        supply_ok = 1'b0;
        step(5);
        supply_ok = 1'b1;
        step(PER + 4);
        // loss of enable mid-pulse on a later pulse
        step(PER - 2);
        drv_en = 1'b0;
        step(5);
        drv_en = 1'b1;
        boot_low = 1'b0;
        step(5);

        // R6: both flags high while idle and armed
        cur_req = "R6";
        boot_low = 1'b1;
        boot_ok = 1'b1;
        step(4);
        boot_low = 1'b0;
        boot_ok = 1'b0;
        step(3);

        finish_run();
    end

endmodule